// File: doc/BRIEF.md
# Serial Clock-Calendar Command Port

This block is the device side of a three-wire serial link that software drives by toggling register bits: a frame-enable line, a serial clock line and a data line. While the enable line is high, every falling edge of the serial clock moves the frame forward by one bit. The first eight bits form a command byte and the next eight form a data byte. Both are sent most significant bit first.

The command decides what happens in the data half of the frame. Read commands drive one bit back on the data line after each falling edge. The source can be one byte of a 32-byte battery-backed store, the status byte, the control byte, or a BCD calendar field. The calendar fields arrive on input ports from a time-keeping counter outside this block. Write commands act only when the sixteenth bit has been taken. At that point the block either stores the data byte into the battery store, or runs the flag-clear action: it clears two status bits and raises a one-cycle strobe for the interrupt logic. Dropping the enable line at any point abandons the frame.

Top module: `rtc_serial_if`

## Requirements
- R1: After reset the status byte is 0x90, the control byte equals parameter CTRL_RESET (default 0x3C), store byte i holds 0xA5 XOR (17*i mod 256), and ser_dout, ser_doe and flag_clr_pulse are all 0.
- R2: A bit is taken only on a falling edge of ser_clk seen while ser_en is high. Command bits are shifted in MSB first. If ser_din changes while the clock is held steady, nothing is shifted.
- R3: Commands 0x00..0x1F read the store. After the (9+k)-th falling edge (k = 0..7), ser_dout carries bit 7-k of byte[command] and ser_doe is 1. Data the host presents during a read is ignored.
- R4: Command 0x30 returns the status byte and command 0x31 returns the control byte, with the same bit timing as R3.
- R5: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return tod_sec, tod_min, tod_hour, tod_day, tod_month and tod_year respectively.
- R6: The remaining codes in 0x20..0x2F (0x23 and 0x27..0x2F) return 0x00 with ser_doe high.
- R7: A command in 0x80..0x9F writes the data byte into store[command-0x80] on the sixteenth falling edge.
- R8: Command 0xB1 with data bit 2 set clears status bits 4 and 3 (mask 0x18) on the sixteenth edge and pulses flag_clr_pulse high for exactly one cycle. If data bit 2 is clear, the command has no effect.
- R9: Lowering ser_en abandons the frame and returns the block to the start of a frame. A partly sent write commits nothing, even when ser_en falls in the same cycle as the sixteenth clock fall. After ser_en goes low, ser_doe is 0.
- R10: After sixteen bits the frame is full. Further falling edges change nothing, so ser_dout holds its last bit and no second write or strobe occurs, until ser_en is lowered.
- R11: Commands that are not reads (writes, 0xB1, and undecoded codes such as 0x32) leave ser_doe at 0 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Frame enable from the control register |
| ser_clk | input | 1 | Serial clock from the control register |
| ser_din | input | 1 | Serial data written by the host |
| tod_sec | input | 8 | BCD seconds |
| tod_min | input | 8 | BCD minutes |
| tod_hour | input | 8 | BCD hours |
| tod_day | input | 8 | BCD day of month |
| tod_month | input | 8 | BCD month |
| tod_year | input | 8 | BCD two-digit year |
| ser_dout | output | 1 | Registered serial read-back bit |
| ser_doe | output | 1 | High while ser_dout carries read data |
| flag_clr_pulse | output | 1 | One-cycle strobe from the flag-clear command |

## Verification
The commit of a write and the abort of a frame can land in the same clock cycle. The bench provokes this by lowering ser_en on the very negedge where it drops ser_clk for the sixteenth bit of a store write, so the edge and the abort reach the same sampling posedge. The outcome is judged through the normal interface: a later read of the target byte must still return its reset contents, and the strobe counter must not move. A partial write aborted after four data bits is judged the same way.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

    localparam int BYTE_W    = 8;
    localparam int RAM_WORDS = 32;
    localparam int ADDR_W    = $clog2(RAM_WORDS);
    localparam int CMD_BITS  = BYTE_W;
    localparam int FRAME_LEN = 2 * BYTE_W;
    localparam int PHASE_W   = $clog2(FRAME_LEN) + 1;
    localparam int BIDX_W    = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0]                 byte_t;
    typedef logic [RAM_WORDS-1:0][BYTE_W-1:0]  ram_img_t;

    // flag-clear action: data bit that triggers it, status bits it clears
    localparam int    FLAG_TRIG_BIT = 2;
    localparam byte_t STAT_CLR_MASK = 8'h18;

    localparam byte_t SEED_BASE = 8'hA5;
    localparam int    SEED_STEP = 17;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_RAM_RD,
        CK_TIME_RD,
        CK_STAT_RD,
        CK_CTRL_RD,
        CK_RAM_WR,
        CK_FLAG_WR
    } cmd_kind_e;

    typedef struct packed {
        byte_t sec;
        byte_t mnt;
        byte_t hr;
        byte_t day;
        byte_t mon;
        byte_t yr;
    } tod_bcd_t;

    typedef struct packed {
        logic  fire;
        byte_t cmd;
        byte_t val;
    } commit_t;

    function automatic cmd_kind_e classify(input byte_t c);
        cmd_kind_e k;
        if (c <= 8'h1F)                    k = CK_RAM_RD;
        else if (c <= 8'h2F)               k = CK_TIME_RD;
        else if (c == 8'h30)               k = CK_STAT_RD;
        else if (c == 8'h31)               k = CK_CTRL_RD;
        else if (c >= 8'h80 && c <= 8'h9F) k = CK_RAM_WR;
        else if (c == 8'hB1)               k = CK_FLAG_WR;
        else                               k = CK_NONE;
        return k;
    endfunction

    function automatic logic kind_is_read(input cmd_kind_e k);
        return (k == CK_RAM_RD) || (k == CK_TIME_RD) ||
               (k == CK_STAT_RD) || (k == CK_CTRL_RD);
    endfunction

    // calendar field selected by the low nibble of a 0x2X command
    function automatic byte_t time_field(input byte_t c, input tod_bcd_t t);
        byte_t r;
        case (c[3:0])
            4'h0:    r = t.sec;
            4'h1:    r = t.mnt;
            4'h2:    r = t.hr;
            4'h4:    r = t.day;
            4'h5:    r = t.mon;
            4'h6:    r = t.yr;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic ram_img_t ram_seed();
        ram_img_t img;
        for (int i = 0; i < RAM_WORDS; i++) begin
            img[i] = SEED_BASE ^ byte_t'(i * SEED_STEP);
        end
        return img;
    endfunction

endpackage

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame
    import rtc_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sclk,
    input  logic              sdin,
    output byte_t             cmd,
    output logic              data_fall,
    output logic [BIDX_W-1:0] bit_idx,
    output commit_t           commit
);

    localparam logic [PHASE_W-1:0] PH_DATA = PHASE_W'(CMD_BITS);
    localparam logic [PHASE_W-1:0] PH_FULL = PHASE_W'(FRAME_LEN);
    localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(FRAME_LEN - 1);

    logic               sclk_q;
    logic [PHASE_W-1:0] phase_q;
    byte_t              cmd_q;
    byte_t              val_q;
    logic               fall;

    assign fall = en && sclk_q && !sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            phase_q <= '0;
            cmd_q   <= '0;
            val_q   <= '0;
        end else begin
            sclk_q <= sclk;
            if (!en) begin
                phase_q <= '0;
                cmd_q   <= '0;
                val_q   <= '0;
            end else if (fall && phase_q < PH_FULL) begin
                phase_q <= phase_q + 1'b1;
                if (phase_q < PH_DATA) begin
                    cmd_q <= {cmd_q[BYTE_W-2:0], sdin};
                end else begin
                    val_q <= {val_q[BYTE_W-2:0], sdin};
                end
            end
        end
    end

    assign cmd         = cmd_q;
    assign data_fall   = fall && (phase_q >= PH_DATA) && (phase_q < PH_FULL);
    assign bit_idx     = ~phase_q[BIDX_W-1:0];
    assign commit.fire = fall && (phase_q == PH_LAST);
    assign commit.cmd  = cmd_q;
    assign commit.val  = {val_q[BYTE_W-2:0], sdin};

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase_q == '0 && cmd_q == '0 && val_q == '0));

    // R10
    frame_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && phase_q == PH_FULL) |=> (phase_q == PH_FULL && $stable(val_q)));

endmodule

// File: rtl/rtc_ser_store.sv
module rtc_ser_store
    import rtc_ser_pkg::*;
#(
    parameter ram_img_t RAM_INIT     = ram_seed(),
    parameter byte_t    STATUS_RESET = 8'h90,
    parameter byte_t    CTRL_RESET   = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_byte,
    output byte_t             status,
    output byte_t             ctrl,
    output logic              clr_pulse
);

    ram_img_t  ram_q;
    byte_t     status_q;
    logic      clr_q;
    cmd_kind_e wkind;

    assign wkind = classify(commit.cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_q    <= RAM_INIT;
            status_q <= STATUS_RESET;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (commit.fire) begin
                if (wkind == CK_RAM_WR) begin
                    ram_q[commit.cmd[ADDR_W-1:0]] <= commit.val;
                end else if (wkind == CK_FLAG_WR && commit.val[FLAG_TRIG_BIT]) begin
                    status_q <= status_q & ~STAT_CLR_MASK;
                    clr_q    <= 1'b1;
                end
            end
        end
    end

    assign rd_byte   = ram_q[rd_addr];
    assign status    = status_q;
    assign ctrl      = CTRL_RESET;
    assign clr_pulse = clr_q;

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> ((status_q & STAT_CLR_MASK) == '0));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !clr_q);

endmodule

// File: rtl/rtc_ser_drive.sv
module rtc_ser_drive
    import rtc_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  byte_t             cmd,
    input  logic              data_fall,
    input  logic [BIDX_W-1:0] bit_idx,
    input  byte_t             ram_byte,
    input  byte_t             status,
    input  byte_t             ctrl,
    input  tod_bcd_t          tod,
    output logic              dout,
    output logic              doe
);

    cmd_kind_e kind;
    byte_t     sel_byte;
    logic      dout_q;
    logic      doe_q;

    assign kind = classify(cmd);

    always_comb begin
        case (kind)
            CK_RAM_RD:  sel_byte = ram_byte;
            CK_TIME_RD: sel_byte = time_field(cmd, tod);
            CK_STAT_RD: sel_byte = status;
            CK_CTRL_RD: sel_byte = ctrl;
            default:    sel_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b0;
            doe_q  <= 1'b0;
        end else if (!en) begin
            dout_q <= 1'b0;
            doe_q  <= 1'b0;
        end else if (data_fall && kind_is_read(kind)) begin
            dout_q <= sel_byte[bit_idx];
            doe_q  <= 1'b1;
        end
    end

    assign dout = dout_q;
    assign doe  = doe_q;

    // R11
    drive_only_reads_chk: assert property (@(posedge clk) disable iff (rst)
        doe_q |-> kind_is_read(kind));

    // R9
    drive_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !doe_q);

endmodule

// File: rtl/rtc_serial_if.sv
module rtc_serial_if
    import rtc_ser_pkg::*;
#(
    parameter ram_img_t RAM_INIT     = ram_seed(),
    parameter byte_t    STATUS_RESET = 8'h90,
    parameter byte_t    CTRL_RESET   = 8'h3C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_en,
    input  logic       ser_clk,
    input  logic       ser_din,
    input  logic [7:0] tod_sec,
    input  logic [7:0] tod_min,
    input  logic [7:0] tod_hour,
    input  logic [7:0] tod_day,
    input  logic [7:0] tod_month,
    input  logic [7:0] tod_year,
    output logic       ser_dout,
    output logic       ser_doe,
    output logic       flag_clr_pulse
);

    byte_t             cmd;
    logic              data_fall;
    logic [BIDX_W-1:0] bit_idx;
    commit_t           commit;
    byte_t             ram_byte;
    byte_t             status;
    byte_t             ctrl;
    tod_bcd_t          tod;

    assign tod = '{sec: tod_sec, mnt: tod_min, hr: tod_hour,
                   day: tod_day, mon: tod_month, yr: tod_year};

    rtc_ser_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .en        (ser_en),
        .sclk      (ser_clk),
        .sdin      (ser_din),
        .cmd       (cmd),
        .data_fall (data_fall),
        .bit_idx   (bit_idx),
        .commit    (commit)
    );

    rtc_ser_store #(
        .RAM_INIT     (RAM_INIT),
        .STATUS_RESET (STATUS_RESET),
        .CTRL_RESET   (CTRL_RESET)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .rd_addr   (cmd[ADDR_W-1:0]),
        .rd_byte   (ram_byte),
        .status    (status),
        .ctrl      (ctrl),
        .clr_pulse (flag_clr_pulse)
    );

    rtc_ser_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .en        (ser_en),
        .cmd       (cmd),
        .data_fall (data_fall),
        .bit_idx   (bit_idx),
        .ram_byte  (ram_byte),
        .status    (status),
        .ctrl      (ctrl),
        .tod       (tod),
        .dout      (ser_dout),
        .doe       (ser_doe)
    );

endmodule

// File: tb/rtc_serial_if_tb.sv
`timescale 1ns/1ps
module rtc_serial_if_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic [7:0] tod_sec = 8'h59, tod_min = 8'h07, tod_hour = 8'h23;
    logic [7:0] tod_day = 8'h31, tod_month = 8'h12, tod_year = 8'h24;
    logic       ser_dout, ser_doe, flag_clr_pulse;

    int checks = 0;
    int errors = 0;
    int clr_cnt = 0;

    always #4 clk = ~clk;

    rtc_serial_if u_dut (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
        .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
        .tod_day(tod_day), .tod_month(tod_month), .tod_year(tod_year),
        .ser_dout(ser_dout), .ser_doe(ser_doe), .flag_clr_pulse(flag_clr_pulse)
    );

    always @(negedge clk) if (!rst && flag_clr_pulse) clr_cnt++;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] wd;
        logic [7:0] exp;
        logic       doe;
        logic       clr;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h00, 8'h00, 8'hA5, 1'b1, 1'b0},
        '{8'h05, 8'hFF, 8'hF0, 1'b1, 1'b0},
        '{8'h1F, 8'h00, 8'hAA, 1'b1, 1'b0},
        '{8'h30, 8'h00, 8'h90, 1'b1, 1'b0},
        '{8'h31, 8'h00, 8'h3C, 1'b1, 1'b0},
        '{8'h20, 8'h00, 8'h59, 1'b1, 1'b0},
        '{8'h21, 8'h00, 8'h07, 1'b1, 1'b0},
        '{8'h22, 8'h00, 8'h23, 1'b1, 1'b0},
        '{8'h24, 8'h00, 8'h31, 1'b1, 1'b0},
        '{8'h25, 8'h00, 8'h12, 1'b1, 1'b0},
        '{8'h26, 8'h00, 8'h24, 1'b1, 1'b0},
        '{8'h23, 8'hFF, 8'h00, 1'b1, 1'b0},
        '{8'h2F, 8'h00, 8'h00, 1'b1, 1'b0},
        '{8'h85, 8'h3E, 8'h00, 1'b0, 1'b0},
        '{8'h05, 8'h00, 8'h3E, 1'b1, 1'b0},
        '{8'h9F, 8'hC3, 8'h00, 1'b0, 1'b0},
        '{8'h1F, 8'h00, 8'hC3, 1'b1, 1'b0},
        '{8'hB1, 8'hFB, 8'h00, 1'b0, 1'b0},
        '{8'h30, 8'h00, 8'h90, 1'b1, 1'b0},
        '{8'hB1, 8'h04, 8'h00, 1'b0, 1'b1},
        '{8'h30, 8'h00, 8'h80, 1'b1, 1'b0}
    };

    function automatic string tag_of(input logic [7:0] c);
        if (c <= 8'h1F) return "R3";
        if (c == 8'h30 || c == 8'h31) return "R4";
        if (c == 8'h20 || c == 8'h21 || c == 8'h22 ||
            c == 8'h24 || c == 8'h25 || c == 8'h26) return "R5";
        if (c[7:4] == 4'h2) return "R6";
        if (c >= 8'h80 && c <= 8'h9F) return "R7";
        if (c == 8'hB1) return "R8";
        return "R11";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_bit(input logic b);
        ser_clk = 1'b1;
        ser_din = b;
        tick(2);
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] w, input bit keep_open,
                         output logic [7:0] rb, output logic doe_s);
        ser_en = 1'b1;
        tick(2);
        for (int i = 7; i >= 0; i--) fall_bit(c[i]);
        for (int i = 7; i >= 0; i--) begin
            fall_bit(w[i]);
            rb[i] = ser_dout;
        end
        doe_s = ser_doe;
        if (!keep_open) begin
            ser_en = 1'b0;
            tick(2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic       ds;
        int         c0;
        tick(3);
        rst = 1'b0;
        tick(2);

        // R1 reset outputs and initial contents
        check(ser_dout == 1'b0 && ser_doe == 1'b0 && flag_clr_pulse == 1'b0, "R1",
              {ser_dout, ser_doe, flag_clr_pulse}, 0);
        frame(8'h0A, 8'h00, 1'b0, rb, ds);
        check(rb == 8'h0F, "R1", rb, 8'h0F);
        check(ser_doe == 1'b0, "R9", ser_doe, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            c0 = clr_cnt;
            frame(VECS[v].cmd, VECS[v].wd, 1'b0, rb, ds);
            check(ds == VECS[v].doe, VECS[v].doe ? tag_of(VECS[v].cmd) : "R11",
                  ds, VECS[v].doe);
            if (VECS[v].doe) check(rb == VECS[v].exp, tag_of(VECS[v].cmd), rb, VECS[v].exp);
            check((clr_cnt - c0) == int'(VECS[v].clr), "R8", clr_cnt - c0, VECS[v].clr);
        end

        // R11 undecoded command
        frame(8'h32, 8'hFF, 1'b0, rb, ds);
        check(ds == 1'b0, "R11", ds, 0);

        // R2 data toggles with clock steady shift nothing
        ser_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ser_din = ~ser_din;
            tick(2);
        end
        frame(8'h30, 8'h00, 1'b0, rb, ds);
        check(rb == 8'h80 && ds, "R2", rb, 8'h80);

        // R9 partial write then abort
        ser_en = 1'b1;
        tick(2);
        for (int i = 7; i >= 0; i--) fall_bit(i == 7);
        for (int i = 0; i < 4; i++) fall_bit(1'b1);
        ser_en = 1'b0;
        tick(2);
        check(ser_doe == 1'b0, "R9", ser_doe, 0);
        frame(8'h00, 8'h00, 1'b0, rb, ds);
        check(rb == 8'hA5, "R9", rb, 8'hA5);

        // R9 enable drops in the same cycle as the sixteenth fall
        c0 = clr_cnt;
        ser_en = 1'b1;
        tick(2);
        for (int i = 7; i >= 0; i--) fall_bit(i == 7);
        for (int i = 7; i >= 1; i--) fall_bit(i == 4 || i == 0);
        ser_clk = 1'b1;
        ser_din = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        ser_en = 1'b0;
        tick(3);
        frame(8'h00, 8'h00, 1'b0, rb, ds);
        check(rb == 8'hA5, "R9", rb, 8'hA5);
        check(clr_cnt == c0, "R9", clr_cnt - c0, 0);

        // R10 extra edges after a full read frame
        frame(8'h1F, 8'h00, 1'b1, rb, ds);
        check(rb == 8'hC3, "R10", rb, 8'hC3);
        for (int i = 0; i < 3; i++) fall_bit(1'b0);
        check(ser_dout == 1'b1 && ser_doe == 1'b1, "R10", {ser_dout, ser_doe}, 2'b11);
        ser_en = 1'b0;
        tick(2);

        // R10 extra edges after a flag-clear frame give one strobe only
        c0 = clr_cnt;
        frame(8'hB1, 8'h04, 1'b1, rb, ds);
        for (int i = 0; i < 3; i++) fall_bit(1'b1);
        ser_en = 1'b0;
        tick(2);
        check(clr_cnt - c0 == 1, "R10", clr_cnt - c0, 1);

        // R10 extra edges after a store write do not write again
        frame(8'h83, 8'h5A, 1'b1, rb, ds);
        for (int i = 0; i < 8; i++) fall_bit(1'b0);
        ser_en = 1'b0;
        tick(2);
        frame(8'h03, 8'h00, 1'b0, rb, ds);
        check(rb == 8'h5A, "R7", rb, 8'h5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule